// File: doc/BRIEF.md
# Multi-Size Translation Lookaside Cache

This block caches completed virtual-to-physical translations so that a requester is not made to wait for a table walk on every access. A lookup presents a virtual address and an address-space tag. One clock later the block answers with either a hit pulse, the physical address and the stored permission bits, or a miss pulse with the address and permission outputs held at zero. Translations for 4KB pages sit in a set-associative array. Translations for 2MB and 1GB pages sit in a small fully associative array. Both arrays are searched in the same cycle.

A walker outside the block writes a finished translation through the fill port. It supplies the virtual page number, the physical page number, the permission bits, the address-space tag, a global flag and a size code. Software-driven maintenance uses a single invalidate port. That port takes a command code and selects one of three actions: drop one page, drop one address space, or drop every entry that is not global. The block has no state machine. Every action completes in the cycle in which it is presented. A lookup always sees the array contents as they stood before any fill or invalidate that arrives in the same cycle.

Top module: `xlate_cache`

## Requirements
- R1: When `lk_valid` is high at a rising edge, exactly one of `rsp_hit` and `rsp_miss` is high during the following cycle. Both are low in every cycle that does not follow a lookup.
- R2: A 4KB translation is stored in set VA[17:12], which is the page number modulo 64. The set holds 4 ways. A lookup hits when an entry is valid, its page number equals VA[47:12], and either the entry is global or its tag equals `lk_asid`.
- R3: Size codes are 0 for 4KB, 1 for 2MB, and 2 or 3 for 1GB. The address output is {ppn,12'b0} with its low 12, 21 or 30 bits replaced by the same bits of the VA. A 2MB entry ignores the low 9 page-number bits when compared, and a 1GB entry ignores the low 18.
- R4: 2MB and 1GB translations occupy an 8-entry fully associative array. If both arrays hit, the 4KB result is returned.
- R5: A 4KB fill takes the lowest-numbered empty way of its set. When the set is full, a binary-tree pseudo-LRU selects the way to replace. In that tree, node n has children 2n+1 and 2n+2, and ways hang from the leaves left to right. A set bit sends the victim search to the right child. Each hit and each fill points every node on the accessed way's path away from that way. The tree bits are zero after reset.
- R6: A large-page fill takes the lowest-numbered empty entry. When the array is full, it replaces the entry named by a round-robin pointer, which starts at 0 and advances by one on each such replacement.
- R7: Invalidate code 0 clears every entry, in either array, whose size-masked page number covers `inv_vpn`, whatever its tag or global flag.
- R8: Invalidate code 1 clears every entry whose tag equals `inv_asid`, global or not.
- R9: Invalidate code 2 clears every non-global entry and keeps global entries. Code 3 changes nothing.
- R10: A fill and an invalidate in the same cycle are applied with the invalidate first, so the fill always survives. A lookup in that same cycle sees the contents from before both.
- R11: After reset every entry is invalid. On a miss, `rsp_pa` and `rsp_perm` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VAW | Virtual address to translate |
| lk_asid | input | ASIDW | Address-space tag of the request |
| rsp_hit | output | 1 | Hit pulse, one cycle after the request |
| rsp_miss | output | 1 | Miss pulse, one cycle after the request |
| rsp_pa | output | PAW | Physical address on a hit, zero otherwise |
| rsp_perm | output | PERMW | Stored permission bits on a hit, zero otherwise |
| fl_valid | input | 1 | Write a translation |
| fl_vpn | input | VAW-12 | Virtual page number of the fill |
| fl_ppn | input | PAW-12 | Physical page number of the fill |
| fl_perm | input | PERMW | Combined permission bits |
| fl_asid | input | ASIDW | Address-space tag of the fill |
| fl_global | input | 1 | Fill is global |
| fl_size | input | 2 | Page size code |
| inv_valid | input | 1 | Invalidate command strobe |
| inv_kind | input | 2 | 0 page, 1 tag, 2 non-global, 3 none |
| inv_vpn | input | VAW-12 | Page number for code 0 |
| inv_asid | input | ASIDW | Tag for code 1 |

## Verification
The two functions that can fall in the same cycle are a fill and an invalidate. The bench drives both strobes on one clock edge in two cases. In the first, a page invalidate covers the very page being filled with a new frame. In the second, a non-global flush coincides with a non-global fill. Each case is judged by a lookup in a later cycle, which must return the newly filled frame. A lookup issued alongside a fill or an invalidate is also checked: it must report the contents from before that cycle, and the next lookup must report the contents from after it.

// File: rtl/xc_pkg.sv
package xc_pkg;

    typedef enum logic [1:0] {
        SZ_4K  = 2'd0,
        SZ_2M  = 2'd1,
        SZ_1G  = 2'd2,
        SZ_1GX = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        INV_PAGE      = 2'd0,
        INV_ASID      = 2'd1,
        INV_NONGLOBAL = 2'd2,
        INV_NOP       = 2'd3
    } inv_kind_e;

    // Number of VA bits passed straight through for a page of this size
    function automatic int unsigned off_bits(input logic is_small, input logic is_1g);
        if (is_small) return 12;
        else if (is_1g) return 30;
        else return 21;
    endfunction

endpackage

// File: rtl/xc_plru.sv
module xc_plru #(
    parameter int SETS = 64,
    parameter int WAYS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hit_en,
    input  logic [$clog2(SETS)-1:0]    hit_set,
    input  logic [$clog2(WAYS)-1:0]    hit_way,
    input  logic                       fill_en,
    input  logic [$clog2(SETS)-1:0]    fill_set,
    input  logic [$clog2(WAYS)-1:0]    fill_way,
    output logic [$clog2(WAYS)-1:0]    vic_way
);
    localparam int WAYW  = $clog2(WAYS);
    localparam int NODES = WAYS - 1;

    logic [NODES-1:0] tree_q [SETS];
    logic [NODES-1:0] fill_base;

    // Point every node on the path of way w away from it
    function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] t,
                                               input logic [WAYW-1:0] w);
        logic [NODES-1:0] r;
        int node;
        int par;
        r    = t;
        node = int'(w) + NODES;
        for (int l = 0; l < WAYW; l++) begin
            par    = (node - 1) / 2;
            r[par] = (node == 2 * par + 1);
            node   = par;
        end
        return r;
    endfunction

    always_comb begin
        int node;
        node = 0;
        for (int l = 0; l < WAYW; l++) begin
            node = 2 * node + 1 + int'(tree_q[fill_set][node]);
        end
        vic_way = WAYW'(node - NODES);
    end

    always_comb begin
        fill_base = tree_q[fill_set];
        if (hit_en && hit_set == fill_set) fill_base = touch(tree_q[fill_set], hit_way);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else begin
            if (hit_en)  tree_q[hit_set]  <= touch(tree_q[hit_set], hit_way);
            if (fill_en) tree_q[fill_set] <= touch(fill_base, fill_way);
        end
    end

endmodule

// File: rtl/xc_set_array.sv
module xc_set_array
    import xc_pkg::*;
#(
    parameter int VPNW  = 36,
    parameter int PPNW  = 40,
    parameter int ASIDW = 8,
    parameter int PERMW = 4,
    parameter int SETS  = 64,
    parameter int WAYS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_en,
    input  logic [VPNW-1:0]  lk_vpn,
    input  logic [ASIDW-1:0] lk_asid,
    output logic             lk_hit,
    output logic [PPNW-1:0]  lk_ppn,
    output logic [PERMW-1:0] lk_perm,
    input  logic             fill_en,
    input  logic [VPNW-1:0]  fill_vpn,
    input  logic [PPNW-1:0]  fill_ppn,
    input  logic [PERMW-1:0] fill_perm,
    input  logic [ASIDW-1:0] fill_asid,
    input  logic             fill_glb,
    input  logic             inv_en,
    input  logic [1:0]       inv_kind,
    input  logic [VPNW-1:0]  inv_vpn,
    input  logic [ASIDW-1:0] inv_asid
);
    localparam int IDXW = $clog2(SETS);
    localparam int WAYW = $clog2(WAYS);
    localparam int TAGW = VPNW - IDXW;

    logic [WAYS-1:0]  v_q   [SETS];
    logic [WAYS-1:0]  g_q   [SETS];
    logic [TAGW-1:0]  tag_q [SETS][WAYS];
    logic [PPNW-1:0]  ppn_q [SETS][WAYS];
    logic [ASIDW-1:0] asid_q[SETS][WAYS];
    logic [PERMW-1:0] perm_q[SETS][WAYS];

    logic [WAYS-1:0]  clr [SETS];
    logic [IDXW-1:0]  lk_set, fill_set, inv_set;
    logic [WAYW-1:0]  lk_way, fill_way, vic_way;
    logic [WAYS-1:0]  keep;
    logic             any_ng;

    assign lk_set   = lk_vpn[IDXW-1:0];
    assign fill_set = fill_vpn[IDXW-1:0];
    assign inv_set  = inv_vpn[IDXW-1:0];

    always_comb begin
        lk_hit  = 1'b0;
        lk_way  = '0;
        lk_ppn  = '0;
        lk_perm = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!lk_hit && v_q[lk_set][w] && tag_q[lk_set][w] == lk_vpn[VPNW-1:IDXW] &&
                (g_q[lk_set][w] || asid_q[lk_set][w] == lk_asid)) begin
                lk_hit  = 1'b1;
                lk_way  = WAYW'(w);
                lk_ppn  = ppn_q[lk_set][w];
                lk_perm = perm_q[lk_set][w];
            end
        end
    end

    always_comb begin
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                unique case (inv_kind_e'(inv_kind))
                    INV_PAGE:      clr[s][w] = inv_en && IDXW'(s) == inv_set &&
                                               tag_q[s][w] == inv_vpn[VPNW-1:IDXW];
                    INV_ASID:      clr[s][w] = inv_en && asid_q[s][w] == inv_asid;
                    INV_NONGLOBAL: clr[s][w] = inv_en && !g_q[s][w];
                    INV_NOP:       clr[s][w] = 1'b0;
                endcase
            end
        end
    end

    always_comb begin
        keep     = v_q[fill_set] & ~clr[fill_set];
        fill_way = vic_way;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!keep[w]) fill_way = WAYW'(w);
        end
    end

    xc_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_en   (lk_en && lk_hit),
        .hit_set  (lk_set),
        .hit_way  (lk_way),
        .fill_en  (fill_en),
        .fill_set (fill_set),
        .fill_way (fill_way),
        .vic_way  (vic_way)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                v_q[s] <= '0;
                g_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < SETS; s++) v_q[s] <= v_q[s] & ~clr[s];
            if (fill_en) begin
                v_q[fill_set][fill_way]    <= 1'b1;
                g_q[fill_set][fill_way]    <= fill_glb;
                tag_q[fill_set][fill_way]  <= fill_vpn[VPNW-1:IDXW];
                ppn_q[fill_set][fill_way]  <= fill_ppn;
                asid_q[fill_set][fill_way] <= fill_asid;
                perm_q[fill_set][fill_way] <= fill_perm;
            end
        end
    end

    always_comb begin
        any_ng = 1'b0;
        for (int s = 0; s < SETS; s++) any_ng = any_ng | |(v_q[s] & ~g_q[s]);
    end

    // R9: a non-global flush with no fill leaves no non-global 4KB entry
    p_small_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && inv_kind == INV_NONGLOBAL && !fill_en) |=> !any_ng);

endmodule

// File: rtl/xc_big_array.sv
module xc_big_array
    import xc_pkg::*;
#(
    parameter int VPNW    = 36,
    parameter int PPNW    = 40,
    parameter int ASIDW   = 8,
    parameter int PERMW   = 4,
    parameter int ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPNW-1:0]  lk_vpn,
    input  logic [ASIDW-1:0] lk_asid,
    output logic             lk_hit,
    output logic             lk_1g,
    output logic [PPNW-1:0]  lk_ppn,
    output logic [PERMW-1:0] lk_perm,
    input  logic             fill_en,
    input  logic             fill_1g,
    input  logic [VPNW-1:0]  fill_vpn,
    input  logic [PPNW-1:0]  fill_ppn,
    input  logic [PERMW-1:0] fill_perm,
    input  logic [ASIDW-1:0] fill_asid,
    input  logic             fill_glb,
    input  logic             inv_en,
    input  logic [1:0]       inv_kind,
    input  logic [VPNW-1:0]  inv_vpn,
    input  logic [ASIDW-1:0] inv_asid
);
    localparam int PW = $clog2(ENTRIES);
    localparam logic [VPNW-1:0] CARE_2M = ~VPNW'((1 << 9) - 1);
    localparam logic [VPNW-1:0] CARE_1G = ~VPNW'((1 << 18) - 1);

    logic [ENTRIES-1:0] v_q, g_q, big_q, clr, keep;
    logic [VPNW-1:0]    vpn_q  [ENTRIES];
    logic [PPNW-1:0]    ppn_q  [ENTRIES];
    logic [ASIDW-1:0]   asid_q [ENTRIES];
    logic [PERMW-1:0]   perm_q [ENTRIES];
    logic [PW-1:0]      rr_q, fill_idx;
    logic               use_rr;

    function automatic logic covers(input logic [VPNW-1:0] stored, input logic is1g,
                                    input logic [VPNW-1:0] probe);
        return ((stored ^ probe) & (is1g ? CARE_1G : CARE_2M)) == '0;
    endfunction

    always_comb begin
        lk_hit  = 1'b0;
        lk_1g   = 1'b0;
        lk_ppn  = '0;
        lk_perm = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (!lk_hit && v_q[e] && covers(vpn_q[e], big_q[e], lk_vpn) &&
                (g_q[e] || asid_q[e] == lk_asid)) begin
                lk_hit  = 1'b1;
                lk_1g   = big_q[e];
                lk_ppn  = ppn_q[e];
                lk_perm = perm_q[e];
            end
        end
    end

    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            unique case (inv_kind_e'(inv_kind))
                INV_PAGE:      clr[e] = inv_en && covers(vpn_q[e], big_q[e], inv_vpn);
                INV_ASID:      clr[e] = inv_en && asid_q[e] == inv_asid;
                INV_NONGLOBAL: clr[e] = inv_en && !g_q[e];
                INV_NOP:       clr[e] = 1'b0;
            endcase
        end
        keep     = v_q & ~clr;
        use_rr   = &keep;
        fill_idx = rr_q;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (!keep[e]) fill_idx = PW'(e);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q   <= '0;
            g_q   <= '0;
            big_q <= '0;
            rr_q  <= '0;
        end else begin
            v_q <= keep;
            if (fill_en) begin
                v_q[fill_idx]    <= 1'b1;
                g_q[fill_idx]    <= fill_glb;
                big_q[fill_idx]  <= fill_1g;
                vpn_q[fill_idx]  <= fill_vpn;
                ppn_q[fill_idx]  <= fill_ppn;
                asid_q[fill_idx] <= fill_asid;
                perm_q[fill_idx] <= fill_perm;
                if (use_rr) rr_q <= rr_q + 1'b1;
            end
        end
    end

    // R6: the round-robin pointer moves only when a full array takes a fill
    p_rr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_en && &(v_q & ~clr)) |=> $stable(rr_q));

    // R9: a non-global flush with no fill leaves only global large entries
    p_big_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && inv_kind == INV_NONGLOBAL && !fill_en) |=> (v_q & ~g_q) == '0);

endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
    import xc_pkg::*;
#(
    parameter int VAW         = 48,
    parameter int PAW         = 52,
    parameter int ASIDW       = 8,
    parameter int PERMW       = 4,
    parameter int SETS        = 64,
    parameter int WAYS        = 4,
    parameter int BIG_ENTRIES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid,
    input  logic [VAW-1:0]       lk_va,
    input  logic [ASIDW-1:0]     lk_asid,
    output logic                 rsp_hit,
    output logic                 rsp_miss,
    output logic [PAW-1:0]       rsp_pa,
    output logic [PERMW-1:0]     rsp_perm,
    input  logic                 fl_valid,
    input  logic [VAW-13:0]      fl_vpn,
    input  logic [PAW-13:0]      fl_ppn,
    input  logic [PERMW-1:0]     fl_perm,
    input  logic [ASIDW-1:0]     fl_asid,
    input  logic                 fl_global,
    input  logic [1:0]           fl_size,
    input  logic                 inv_valid,
    input  logic [1:0]           inv_kind,
    input  logic [VAW-13:0]      inv_vpn,
    input  logic [ASIDW-1:0]     inv_asid
);
    localparam int VPNW = VAW - 12;
    localparam int PPNW = PAW - 12;

    logic             s_hit, b_hit, b_1g, any_hit;
    logic [PPNW-1:0]  s_ppn, b_ppn, sel_ppn;
    logic [PERMW-1:0] s_perm, b_perm, sel_perm;
    logic [PAW-1:0]   off_mask, pa_next;
    logic             small_fill;

    assign small_fill = fl_valid && pg_size_e'(fl_size) == SZ_4K;

    xc_set_array #(
        .VPNW(VPNW), .PPNW(PPNW), .ASIDW(ASIDW), .PERMW(PERMW), .SETS(SETS), .WAYS(WAYS)
    ) u_small (
        .clk(clk), .rst_n(rst_n),
        .lk_en(lk_valid), .lk_vpn(lk_va[VAW-1:12]), .lk_asid(lk_asid),
        .lk_hit(s_hit), .lk_ppn(s_ppn), .lk_perm(s_perm),
        .fill_en(small_fill), .fill_vpn(fl_vpn), .fill_ppn(fl_ppn), .fill_perm(fl_perm),
        .fill_asid(fl_asid), .fill_glb(fl_global),
        .inv_en(inv_valid), .inv_kind(inv_kind), .inv_vpn(inv_vpn), .inv_asid(inv_asid)
    );

    xc_big_array #(
        .VPNW(VPNW), .PPNW(PPNW), .ASIDW(ASIDW), .PERMW(PERMW), .ENTRIES(BIG_ENTRIES)
    ) u_big (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_va[VAW-1:12]), .lk_asid(lk_asid),
        .lk_hit(b_hit), .lk_1g(b_1g), .lk_ppn(b_ppn), .lk_perm(b_perm),
        .fill_en(fl_valid && !small_fill), .fill_1g(pg_size_e'(fl_size) != SZ_2M),
        .fill_vpn(fl_vpn), .fill_ppn(fl_ppn), .fill_perm(fl_perm),
        .fill_asid(fl_asid), .fill_glb(fl_global),
        .inv_en(inv_valid), .inv_kind(inv_kind), .inv_vpn(inv_vpn), .inv_asid(inv_asid)
    );

    // 4KB array wins when both arrays hit
    always_comb begin
        any_hit  = s_hit || b_hit;
        sel_ppn  = s_hit ? s_ppn  : b_ppn;
        sel_perm = s_hit ? s_perm : b_perm;
        off_mask = (PAW'(1) << off_bits(s_hit, b_1g)) - PAW'(1);
        pa_next  = ({sel_ppn, 12'b0} & ~off_mask) | (PAW'(lk_va) & off_mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit  <= 1'b0;
            rsp_miss <= 1'b0;
            rsp_pa   <= '0;
            rsp_perm <= '0;
        end else begin
            rsp_hit  <= lk_valid && any_hit;
            rsp_miss <= lk_valid && !any_hit;
            rsp_pa   <= (lk_valid && any_hit) ? pa_next  : '0;
            rsp_perm <= (lk_valid && any_hit) ? sel_perm : '0;
        end
    end

    // R1: every lookup yields exactly one pulse in the next cycle
    p_one_answer_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rsp_hit ^ rsp_miss));

    // R1: no pulse without a lookup
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_hit && !rsp_miss));

    // R11: a miss carries no address or permission bits
    p_miss_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_pa == '0 && rsp_perm == '0));

endmodule

// File: tb/xlate_cache_bench.sv
module xlate_cache_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic        rsp_hit, rsp_miss;
    logic [51:0] rsp_pa;
    logic [3:0]  rsp_perm;
    logic        fl_valid = 1'b0;
    logic [35:0] fl_vpn = '0;
    logic [39:0] fl_ppn = '0;
    logic [3:0]  fl_perm = '0;
    logic [7:0]  fl_asid = '0;
    logic        fl_global = 1'b0;
    logic [1:0]  fl_size = '0;
    logic        inv_valid = 1'b0;
    logic [1:0]  inv_kind = '0;
    logic [35:0] inv_vpn = '0;
    logic [7:0]  inv_asid = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xlate_cache u_xlate_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pa(rsp_pa), .rsp_perm(rsp_perm),
        .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_ppn(fl_ppn), .fl_perm(fl_perm),
        .fl_asid(fl_asid), .fl_global(fl_global), .fl_size(fl_size),
        .inv_valid(inv_valid), .inv_kind(inv_kind), .inv_vpn(inv_vpn), .inv_asid(inv_asid)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == LIMIT) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1: got cycle %0d, expected end before %0d", cyc, LIMIT);
            summary();
            $finish;
        end
    end

    function automatic logic [51:0] expa(input logic [39:0] ppn, input logic [47:0] va,
                                         input int sz);
        int off;
        logic [63:0] base;
        off  = (sz == 0) ? 12 : (sz == 1) ? 21 : 30;
        base = {12'b0, ppn, 12'b0};
        base = (base >> off) << off;
        return 52'(base | ({16'b0, va} & ((64'd1 << off) - 64'd1)));
    endfunction

    task automatic tick();
        @(negedge clk);
        lk_valid  = 1'b0;
        fl_valid  = 1'b0;
        inv_valid = 1'b0;
    endtask

    task automatic put_fill(input logic [47:0] va, input logic [39:0] ppn, input logic [3:0] perm,
                            input logic [7:0] asid, input logic glb, input logic [1:0] sz);
        fl_valid = 1'b1; fl_vpn = va[47:12]; fl_ppn = ppn; fl_perm = perm;
        fl_asid = asid; fl_global = glb; fl_size = sz;
    endtask

    task automatic put_inv(input logic [1:0] kind, input logic [47:0] va, input logic [7:0] asid);
        inv_valid = 1'b1; inv_kind = kind; inv_vpn = va[47:12]; inv_asid = asid;
    endtask

    task automatic fill(input logic [47:0] va, input logic [39:0] ppn, input logic [3:0] perm,
                        input logic [7:0] asid, input logic glb, input logic [1:0] sz);
        put_fill(va, ppn, perm, asid, glb, sz);
        tick();
    endtask

    task automatic inv(input logic [1:0] kind, input logic [47:0] va, input logic [7:0] asid);
        put_inv(kind, va, asid);
        tick();
    endtask

    // Issue a lookup (optionally alongside whatever is already staged) and check the reply
    task automatic look(input logic [47:0] va, input logic [7:0] asid, input logic eh,
                        input logic [51:0] epa, input logic [3:0] eperm, input string req);
        logic [51:0] xpa;
        logic [3:0]  xperm;
        lk_valid = 1'b1; lk_va = va; lk_asid = asid;
        tick();
        xpa   = eh ? epa : '0;
        xperm = eh ? eperm : '0;
        n_chk++;
        if (rsp_hit !== eh || rsp_miss !== !eh || rsp_pa !== xpa || rsp_perm !== xperm) begin
            n_bad++;
            $display("FAIL %s va=%h: got hit=%b miss=%b pa=%h perm=%h, expected hit=%b pa=%h perm=%h",
                     req, va, rsp_hit, rsp_miss, rsp_pa, rsp_perm, eh, xpa, xperm);
        end
    endtask

    task automatic quiet(input string req);
        n_chk++;
        if (rsp_hit !== 1'b0 || rsp_miss !== 1'b0) begin
            n_bad++;
            $display("FAIL %s: got hit=%b miss=%b, expected 0 0", req, rsp_hit, rsp_miss);
        end
    endtask

    localparam logic [47:0] VA2M = 48'h0000_1240_0000;
    localparam logic [47:0] VA1G = 48'h0080_0000_0000;
    localparam logic [47:0] BIGB = 48'h0001_0000_0000;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        quiet("R11 reset");
        look(48'h0, 8'd0, 1'b0, '0, '0, "R11 empty");
        tick();
        quiet("R1 idle");

        // R2/R3: one 4KB page per set
        for (int s = 0; s < 64; s++)
            fill({12'(s + 1), 6'(s), 12'h0}[47:0] << 18 >> 18 | (48'(s + 1) << 18) | (48'(s) << 12),
                 40'h100 + 40'(s * 3), 4'(s), 8'd5, 1'b0, 2'd0);
        for (int s = 0; s < 64; s++) begin
            logic [47:0] va;
            va = (48'(s + 1) << 18) | (48'(s) << 12) | 48'((s * 13) & 12'hfff);
            look(va, 8'd5, 1'b1, expa(40'h100 + 40'(s * 3), va, 0), 4'(s), "R2 set hit");
            look(va, 8'd6, 1'b0, '0, '0, "R2 tag mismatch");
            look((48'(s + 2) << 18) | (48'(s) << 12), 8'd5, 1'b0, '0, '0, "R2 vpn mismatch");
        end
        inv(2'd2, '0, '0);
        for (int s = 0; s < 64; s++)
            look((48'(s + 1) << 18) | (48'(s) << 12), 8'd5, 1'b0, '0, '0, "R9 flush");

        // Global entry: any tag hits, survives flush, dropped by its own tag (R8)
        fill(48'h0000_0abc_d000, 40'h55, 4'hc, 8'd9, 1'b1, 2'd0);
        look(48'h0000_0abc_d010, 8'd3, 1'b1, 52'h55010, 4'hc, "R2 global");
        inv(2'd2, '0, '0);
        look(48'h0000_0abc_d010, 8'd3, 1'b1, 52'h55010, 4'hc, "R9 global kept");
        inv(2'd1, '0, 8'd9);
        look(48'h0000_0abc_d010, 8'd9, 1'b0, '0, '0, "R8 global by tag");

        // Large pages (R3, R4, R7)
        fill(VA2M, 40'ha00, 4'h3, 8'd1, 1'b0, 2'd1);
        fill(VA1G, 40'h40000, 4'h5, 8'd1, 1'b0, 2'd2);
        look(VA2M + 48'h1f_ffff, 8'd1, 1'b1, expa(40'ha00, VA2M + 48'h1f_ffff, 1), 4'h3, "R3 2M top");
        look(VA2M + 48'h20_0000, 8'd1, 1'b0, '0, '0, "R3 2M beyond");
        look(VA1G + 48'h3fff_ffff, 8'd1, 1'b1, 52'h7fff_ffff, 4'h5, "R3 1G top");
        look(VA1G + 48'h4000_0000, 8'd1, 1'b0, '0, '0, "R3 1G beyond");
        fill(VA2M + 48'h5000, 40'h777, 4'h9, 8'd1, 1'b0, 2'd0);
        look(VA2M + 48'h5123, 8'd1, 1'b1, 52'h777123, 4'h9, "R4 small wins");
        look(VA2M + 48'h6123, 8'd1, 1'b1, 52'ha06123, 4'h3, "R4 large used");
        inv(2'd0, VA2M + 48'h5000, 8'd77);
        look(VA2M + 48'h5123, 8'd1, 1'b0, '0, '0, "R7 page small+large");
        look(VA2M + 48'h10, 8'd1, 1'b0, '0, '0, "R7 covering large");
        look(VA1G + 48'h10, 8'd1, 1'b1, 52'h4000_0010, 4'h5, "R7 other kept");

        // R6: large-array round robin
        inv(2'd2, '0, '0);
        for (int i = 0; i < 9; i++)
            fill(BIGB + 48'(i) * 48'h20_0000, 40'h2000 + 40'(i) * 40'h200, 4'h1, 8'd2, 1'b0, 2'd1);
        look(BIGB, 8'd2, 1'b0, '0, '0, "R6 first replaced");
        for (int i = 1; i < 9; i++)
            look(BIGB + 48'(i) * 48'h20_0000 + 48'h44, 8'd2, 1'b1,
                 52'({40'h2000 + 40'(i) * 40'h200, 12'h044}), 4'h1, "R6 kept");
        fill(BIGB + 48'(9) * 48'h20_0000, 40'h4000, 4'h1, 8'd2, 1'b0, 2'd1);
        look(BIGB + 48'h20_0000, 8'd2, 1'b0, '0, '0, "R6 second replaced");
        look(BIGB + 48'(9) * 48'h20_0000, 8'd2, 1'b1, 52'h4000000, 4'h1, "R6 newest");

        // R5: pseudo-LRU in set 10
        inv(2'd2, '0, '0);
        for (int k = 1; k <= 4; k++)
            fill((48'(k) << 18) | (48'd10 << 12), 40'(k), 4'(k), 8'd4, 1'b0, 2'd0);
        look((48'd1 << 18) | (48'd10 << 12), 8'd4, 1'b1, 52'h1000, 4'd1, "R5 touch A");
        fill((48'd5 << 18) | (48'd10 << 12), 40'd5, 4'd5, 8'd4, 1'b0, 2'd0);
        look((48'd3 << 18) | (48'd10 << 12), 8'd4, 1'b0, '0, '0, "R5 C evicted");
        look((48'd1 << 18) | (48'd10 << 12), 8'd4, 1'b1, 52'h1000, 4'd1, "R5 A kept");
        look((48'd2 << 18) | (48'd10 << 12), 8'd4, 1'b1, 52'h2000, 4'd2, "R5 B kept");
        look((48'd4 << 18) | (48'd10 << 12), 8'd4, 1'b1, 52'h4000, 4'd4, "R5 D kept");
        look((48'd5 << 18) | (48'd10 << 12), 8'd4, 1'b1, 52'h5000, 4'd5, "R5 E placed");
        fill((48'd6 << 18) | (48'd10 << 12), 40'd6, 4'd6, 8'd4, 1'b0, 2'd0);
        look((48'd1 << 18) | (48'd10 << 12), 8'd4, 1'b0, '0, '0, "R5 A evicted");
        look((48'd6 << 18) | (48'd10 << 12), 8'd4, 1'b1, 52'h6000, 4'd6, "R5 F placed");
        look((48'd2 << 18) | (48'd10 << 12), 8'd4, 1'b1, 52'h2000, 4'd2, "R5 B still");

        // R10: fill and invalidate together; lookup sees old contents
        fill(48'h0000_3333_3000, 40'h11, 4'h2, 8'd7, 1'b0, 2'd0);
        put_inv(2'd0, 48'h0000_3333_3000, 8'd0);
        put_fill(48'h0000_3333_3000, 40'h22, 4'h6, 8'd7, 1'b0, 2'd0);
        look(48'h0000_3333_3abc, 8'd7, 1'b1, 52'h11abc, 4'h2, "R10 lookup sees old");
        look(48'h0000_3333_3abc, 8'd7, 1'b1, 52'h22abc, 4'h6, "R10 fill after page inv");
        put_inv(2'd2, '0, '0);
        put_fill(48'h0000_4444_4000, 40'h33, 4'h7, 8'd7, 1'b0, 2'd0);
        tick();
        look(48'h0000_4444_4001, 8'd7, 1'b1, 52'h33001, 4'h7, "R10 fill after flush");
        look(48'h0000_3333_3abc, 8'd7, 1'b0, '0, '0, "R10 flush applied");
        put_fill(48'h0000_5555_5000, 40'h44, 4'h1, 8'd7, 1'b0, 2'd0);
        look(48'h0000_5555_5000, 8'd7, 1'b0, '0, '0, "R10 fill not yet seen");
        look(48'h0000_5555_5000, 8'd7, 1'b1, 52'h44000, 4'h1, "R10 fill seen");

        // R9 code 3, R8 selective tag
        inv(2'd3, 48'h0000_5555_5000, 8'd7);
        look(48'h0000_5555_5000, 8'd7, 1'b1, 52'h44000, 4'h1, "R9 code3 no effect");
        fill(48'h0000_6666_6000, 40'h66, 4'h3, 8'd1, 1'b0, 2'd0);
        fill(48'h0000_7777_7000, 40'h77, 4'h3, 8'd2, 1'b0, 2'd0);
        inv(2'd1, '0, 8'd1);
        look(48'h0000_6666_6000, 8'd1, 1'b0, '0, '0, "R8 tag cleared");
        look(48'h0000_7777_7000, 8'd2, 1'b1, 52'h77000, 4'h3, "R8 other tag kept");
        tick();
        quiet("R1 idle end");

        summary();
        $finish;
    end

endmodule